// File: doc/BRIEF.md
# Serial Switch-Bank Control Slave

This block is the two-wire serial front end of a register-controlled analog switch bank. It oversamples the bus clock and data lines with a fast system clock, resynchronises and deglitches them, and recognises start and stop conditions. It answers a 7-bit device address of which the four upper bits are fixed and the three lower bits come from strap inputs. The block never drives the clock line; it pulls the data line low through an open-drain enable.

A write frame is the address byte followed by two data bytes, a command byte and a mode byte. Once both have been acknowledged, the block hands them to the command unit as one 16-bit word with a one-cycle strobe. A read frame returns a 16-bit status word as two bytes. The word is captured when the address is accepted, so it cannot tear while being shifted out. The state machine has seven states. IDLE waits for a start. ADDR shifts in the address byte. ADDR_ACK drives the address acknowledge. WR_BYTE shifts in a data byte. WR_ACK acknowledges that byte and either returns to WR_BYTE (first byte) or emits the word and goes to IDLE (second byte). RD_BYTE shifts out a status byte. RD_ACK samples the master's acknowledge and either returns to RD_BYTE or goes to IDLE. From every state, a start goes to ADDR and a stop goes to IDLE. A non-matching address goes from ADDR to IDLE.

Top module: `swctl_i2c_slave`

## Requirements
- R1: While reset is asserted and in the cycle after it, `sda_oe` is 0 and `cmd_valid` is 0.
- R2: The address byte carries the device address in bits 7..1, MSB first, with bit 0 as R/W (1 = read, 0 = write). The address matches when bits 7..4 are 1,0,1,0 and bits 3..1 equal `strap_addr[2:0]`. On a match the block holds SDA low during the ninth clock pulse. On a mismatch it never drives SDA, so later bytes get no acknowledge and no word is emitted.
- R3: In a matched write, both data bytes are acknowledged. After the ninth pulse of the second byte, `cmd_valid` pulses for exactly one cycle with `cmd_word` = {first byte, second byte}.
- R4: A stop or a repeated start arriving before the second data byte has been acknowledged discards the partial word, and no `cmd_valid` results from it.
- R5: In a matched read, the block sends `status_word[15:8]` and then `status_word[7:0]`, MSB first, each bit stable while SCL is high. A master acknowledge (SDA low) after the first byte continues with the second byte. A not-acknowledge after either byte releases SDA for the rest of the frame.
- R6: The status word is captured when a read address is accepted; later changes of `status_word` do not alter the bytes sent in that frame.
- R7: Pulses on SCL or SDA that last fewer than SPIKE_CYC system clocks have no effect. This covers an SCL spike during the low phase and an SDA spike during the high phase.
- R8: A start seen in any state, including in the middle of a byte, restarts address reception with a cleared bit count and releases SDA.
- R9: The block changes `sda_oe` only HOLD_CYC clocks after a filtered SCL falling edge, never while SCL is high in a well-formed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_addr | input | 3 | Strapped low address bits (bit 2 is the highest) |
| status_word | input | 16 | Status value offered for reads |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cmd_word | output | 16 | Command byte in bits 15..8, mode byte in bits 7..0 |
| cmd_valid | output | 1 | One-cycle strobe marking a new `cmd_word` |

## Verification
Two functions can land in the same cycle: start detection, and the pending progress of a byte or of the write-word hand-off. When both fire, the start has to win and wipe the partial frame. The bench provokes this with a repeated start in the middle of a data byte and another right after the first data byte's acknowledge, each followed by a full write. It judges the outcome by counting `cmd_valid` strobes at the port and comparing the one word that should appear. Glitch suppression is checked the same way: spikes on SCL or SDA are injected inside a write, and the bench requires the exact word to come through anyway.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int ADDR_W = 7;
    localparam int STRAP_W = 3;
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } swctl_state_e;
endpackage

// File: rtl/swctl_glitch_filt.sv
module swctl_glitch_filt #(
    parameter int SPIKE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(SPIKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SPIKE_CYC - 1);

    logic          sync1, sync2;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            clean   <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
            if (sync2 == clean) begin
                run_cnt <= '0;
            end else if (run_cnt == LAST) begin
                clean   <= sync2;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swctl_bus_cond.sv
module swctl_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_det = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
endmodule

// File: rtl/swctl_hold_timer.sv
module swctl_hold_timer #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic tick
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC);
    localparam logic [HW-1:0] ONE  = HW'(1);

    logic [HW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == ONE);
endmodule

// File: rtl/swctl_i2c_slave.sv
module swctl_i2c_slave
    import swctl_pkg::*;
#(
    parameter int         SPIKE_CYC = 3,
    parameter int         HOLD_CYC  = 2,
    parameter logic [3:0] ADDR_HI   = 4'b1010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic [STRAP_W-1:0]  strap_addr,
    input  logic [WORD_W-1:0]   status_word,
    output logic                sda_oe,
    output logic [WORD_W-1:0]   cmd_word,
    output logic                cmd_valid
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W - 1);

    logic [1:0] raw_pair, clean_pair;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, start_det, stop_det, drv_tick;

    assign raw_pair = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_filt
            swctl_glitch_filt #(.SPIKE_CYC(SPIKE_CYC)) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (raw_pair[g]),
                .clean (clean_pair[g])
            );
        end
    endgenerate

    assign scl_f = clean_pair[0];
    assign sda_f = clean_pair[1];

    swctl_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    swctl_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (scl_fall),
        .tick  (drv_tick)
    );

    swctl_state_e      state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] cmd_hi;
    logic [WORD_W-1:0] tx_sh;
    logic              rd_mode;
    logic              second;
    logic              mst_ack;
    logic              addr_hit;

    assign addr_hit = (rx_sh[BYTE_W-1:1] == {ADDR_HI, strap_addr});

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            cmd_hi    <= '0;
            tx_sh     <= '0;
            rd_mode   <= 1'b0;
            second    <= 1'b0;
            mst_ack   <= 1'b0;
            cmd_word  <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                second  <= 1'b0;
            end else if (stop_det) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                    end
                    ST_ADDR: begin
                        if (scl_rise && bit_cnt < FULL_CNT) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (drv_tick && bit_cnt == FULL_CNT) begin
                            if (addr_hit) begin
                                state   <= ST_ADDR_ACK;
                                rd_mode <= rx_sh[0];
                                if (rx_sh[0]) begin
                                    tx_sh <= status_word;
                                end
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (drv_tick) begin
                            bit_cnt <= '0;
                            second  <= 1'b0;
                            state   <= rd_mode ? ST_RD_BYTE : ST_WR_BYTE;
                        end
                    end
                    ST_WR_BYTE: begin
                        if (scl_rise && bit_cnt < FULL_CNT) begin
                            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (drv_tick && bit_cnt == FULL_CNT) begin
                            state <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (drv_tick) begin
                            bit_cnt <= '0;
                            if (!second) begin
                                cmd_hi <= rx_sh;
                                second <= 1'b1;
                                state  <= ST_WR_BYTE;
                            end else begin
                                cmd_word  <= {cmd_hi, rx_sh};
                                cmd_valid <= 1'b1;
                                state     <= ST_IDLE;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (drv_tick) begin
                            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                            if (bit_cnt == LAST_CNT) begin
                                bit_cnt <= '0;
                                state   <= ST_RD_ACK;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_f;
                        end else if (drv_tick) begin
                            if (mst_ack && !second) begin
                                second <= 1'b1;
                                state  <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sh[WORD_W-1];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/swctl_i2c_chk.sv
module swctl_i2c_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic start_det,
    input logic sda_oe,
    input logic cmd_valid
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !cmd_valid));

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind swctl_i2c_slave swctl_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_det (start_det),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid)
);

// File: tb/swctl_i2c_slave_bench.sv
module swctl_i2c_slave_bench;
    localparam int Q = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [15:0] status_word = '0;
    logic        sda_oe, cmd_valid;
    logic [15:0] cmd_word;
    logic        sda_in;

    int total = 0;
    int bad = 0;
    int vcnt = 0;
    int hold_bad = 0;
    logic [15:0] last_word = '0;

    assign sda_in = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    swctl_i2c_slave u_swctl_i2c_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_in),
        .strap_addr  (strap),
        .status_word (status_word),
        .sda_oe      (sda_oe),
        .cmd_word    (cmd_word),
        .cmd_valid   (cmd_valid)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            vcnt      <= vcnt + 1;
            last_word <= cmd_word;
        end
    end

    // {rw, addr[6:0], byte1, byte2, status}
    localparam logic [39:0] VEC [0:7] = '{
        {1'b0, 7'h55, 8'h3C, 8'h02, 16'h0000},
        {1'b0, 7'h55, 8'h81, 8'hFF, 16'h0000},
        {1'b0, 7'h54, 8'h11, 8'h22, 16'h0000},
        {1'b1, 7'h55, 8'h00, 8'h00, 16'hA5C3},
        {1'b1, 7'h57, 8'h00, 8'h00, 16'h1234},
        {1'b0, 7'h15, 8'h5A, 8'hA5, 16'h0000},
        {1'b1, 7'h55, 8'h00, 8'h00, 16'h8001},
        {1'b0, 7'h55, 8'h00, 8'h01, 16'h0000}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // mode 1: SCL spike in low phase; mode 2: SDA spike in high phase
    task automatic bit_cycle(input logic b, input int mode, output logic r);
        logic r1;
        sda_m = b;
        wait_clk(Q);
        if (mode == 1) begin
            scl_m = 1'b1; wait_clk(2); scl_m = 1'b0; wait_clk(Q);
        end
        scl_m = 1'b1;
        wait_clk(Q / 2);
        r1 = sda_in;
        if (mode == 2) begin
            sda_m = ~b; wait_clk(2); sda_m = b;
        end
        wait_clk(Q / 2);
        r = sda_in;
        if (r != r1) hold_bad++;
        wait_clk(Q);
        scl_m = 1'b0;
        wait_clk(2);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input int mode, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(d[i], mode, r);
        bit_cycle(1'b1, 0, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, 0, r);
            d = {d[6:0], r};
        end
        bit_cycle(~mack, 0, r);
    endtask

    task automatic write_frame(input logic [6:0] ad, input logic [7:0] d1,
                               input logic [7:0] d2, input int mode,
                               output logic a0, output logic a1, output logic a2);
        i2c_start();
        send_byte({ad, 1'b0}, 0, a0);
        send_byte(d1, mode, a1);
        send_byte(d2, mode, a2);
        i2c_stop();
        wait_clk(4);
    endtask

    initial begin : watchdog
        wait_clk(190000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic a0, a1, a2, r;
        logic [7:0] b1, b2;
        int base;

        wait_clk(5);
        chk(sda_oe == 1'b0, "R1 sda_oe in reset", 32'(sda_oe), 0);
        rst_n = 1'b1;
        wait_clk(1);
        chk(sda_oe == 1'b0 && cmd_valid == 1'b0, "R1 quiet after reset",
            {30'd0, sda_oe, cmd_valid}, 0);
        wait_clk(10);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            logic [39:0] v;
            logic rw, exp_ack;
            logic [6:0] ad;
            v = VEC[i];
            rw = v[39];
            ad = v[38:32];
            exp_ack = (ad == {4'b1010, strap});
            status_word = v[15:0];
            base = vcnt;
            if (!rw) begin
                write_frame(ad, v[31:24], v[23:16], 0, a0, a1, a2);
                chk(a0 == exp_ack, "R2 address ack on write", 32'(a0), 32'(exp_ack));
                chk(a1 == exp_ack && a2 == exp_ack, "R3 data ack / R2 ignored",
                    {30'd0, a1, a2}, {30'd0, exp_ack, exp_ack});
                chk(vcnt - base == (exp_ack ? 1 : 0), "R3 strobe count",
                    32'(vcnt - base), exp_ack ? 1 : 0);
                if (exp_ack)
                    chk(last_word == v[31:16], "R3 command word",
                        32'(last_word), 32'(v[31:16]));
            end else begin
                i2c_start();
                send_byte({ad, 1'b1}, 0, a0);
                chk(a0 == exp_ack, "R2 address ack on read", 32'(a0), 32'(exp_ack));
                if (exp_ack) begin
                    recv_byte(1'b1, b1);
                    recv_byte(1'b0, b2);
                    chk({b1, b2} == v[15:0], "R5 status bytes",
                        32'({b1, b2}), 32'(v[15:0]));
                    bit_cycle(1'b1, 0, r);
                    chk(r == 1'b1, "R5 released after nack", 32'(r), 1);
                end
                i2c_stop();
                wait_clk(4);
            end
        end

        // R4: stop after first data byte discards word
        base = vcnt;
        i2c_start();
        send_byte(8'hAA, 0, a0);
        send_byte(8'h77, 0, a1);
        i2c_stop();
        wait_clk(4);
        chk(vcnt == base, "R4 stop discards partial", 32'(vcnt - base), 0);

        // R4: repeated start after first data byte, then full write
        base = vcnt;
        i2c_start();
        send_byte(8'hAA, 0, a0);
        send_byte(8'h66, 0, a1);
        i2c_start();
        send_byte(8'hAA, 0, a0);
        send_byte(8'h5A, 0, a1);
        send_byte(8'h03, 0, a2);
        i2c_stop();
        wait_clk(4);
        chk(vcnt - base == 1, "R4 repeated start count", 32'(vcnt - base), 1);
        chk(last_word == 16'h5A03, "R4 word after repeated start", 32'(last_word), 32'h5A03);

        // R8: start in the middle of a data byte
        base = vcnt;
        i2c_start();
        send_byte(8'hAA, 0, a0);
        for (int k = 0; k < 4; k++) bit_cycle(k[0], 0, r);
        i2c_start();
        send_byte(8'hAA, 0, a0);
        send_byte(8'h99, 0, a1);
        send_byte(8'h01, 0, a2);
        i2c_stop();
        wait_clk(4);
        chk(vcnt - base == 1 && a0, "R8 mid-byte start restarts", 32'(vcnt - base), 1);
        chk(last_word == 16'h9901, "R8 word after mid-byte start", 32'(last_word), 32'h9901);

        // R6: status captured at address accept
        status_word = 16'hC33C;
        i2c_start();
        send_byte(8'hAB, 0, a0);
        status_word = 16'h0FF0;
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        i2c_stop();
        wait_clk(4);
        chk({b1, b2} == 16'hC33C, "R6 status latched", 32'({b1, b2}), 32'hC33C);

        // R5: nack on first byte ends the read
        status_word = 16'hFF00;
        i2c_start();
        send_byte(8'hAB, 0, a0);
        recv_byte(1'b0, b1);
        recv_byte(1'b0, b2);
        i2c_stop();
        wait_clk(4);
        chk(b1 == 8'hFF && b2 == 8'hFF, "R5 nack on first byte ends read",
            32'({b1, b2}), 32'hFFFF);

        // R7: SCL spikes in low phase, SDA spikes in high phase
        base = vcnt;
        write_frame(7'h55, 8'hC6, 8'h39, 1, a0, a1, a2);
        chk(vcnt - base == 1 && last_word == 16'hC639, "R7 SCL spikes suppressed",
            32'(last_word), 32'hC639);
        base = vcnt;
        write_frame(7'h55, 8'h6D, 8'hB2, 2, a0, a1, a2);
        chk(vcnt - base == 1 && last_word == 16'h6DB2, "R7 SDA spikes suppressed",
            32'(last_word), 32'h6DB2);

        // R2: new strap value
        strap = 3'b010;
        wait_clk(4);
        base = vcnt;
        write_frame(7'h52, 8'h12, 8'h34, 0, a0, a1, a2);
        chk(a0 && vcnt - base == 1 && last_word == 16'h1234, "R2 strap 010 accepted",
            32'(last_word), 32'h1234);
        base = vcnt;
        write_frame(7'h55, 8'h12, 8'h35, 0, a0, a1, a2);
        chk(!a0 && vcnt == base, "R2 old strap address ignored",
            32'(vcnt - base), 0);

        // R9: SDA never moved during an SCL high phase
        chk(hold_bad == 0, "R9 SDA stable while SCL high", 32'(hold_bad), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule